// File: doc/BRIEF.md
# Dual-Port RAM with Contention Arbiter

A 2048 x 8 static memory with two independent ports, left and right. Each port has its own active-low select, a read/write control, an active-low output enable, an 11-bit address, write data, and registered read data with a valid flag. The whole block runs on one clock. Each port's control and data pins are plain, level-sampled signals. There is no valid/ready handshake. A port cannot be back-pressured except through its busy flag, and the driving agent is expected to hold its access while that flag is low.

When both ports are selected at the same address, the access is contended. As master (`is_master` = 1), the block's own arbiter picks one winner. It drives the loser's active-low busy output low in that same cycle, and the loser's access is discarded. The arbiter uses one cycle of history. If both ports were already selected in the previous cycle, the port whose address did not move wins. Otherwise, the port that was selected in the previous cycle wins. A winner keeps the grant for as long as the contention lasts.

As slave (`is_master` = 0), the block does no arbitration. Several slaves can be ganged beside one master to widen the data path. The busy inputs come from the master, and a port whose busy input is low loses its access. This keeps every device in the group agreeing on one winner.

Top module: `dp_ram_arb`

## Requirements
- R1: A selected port with `we_n`=0 stores `wdata` at `addr` on the clock edge. A selected port with `we_n`=1 and `oe_n`=0 is a read, and it returns the word stored before that edge on `rdata` with `rvalid`=1 in the following cycle.
- R2: A port with `cs_n`=1 performs no access. Its write does not change memory and its `rvalid` is 0 in the next cycle.
- R3: `rvalid` is 1 only in the cycle after a selected, uninhibited read with `oe_n`=0. Whenever `rvalid` is 0, `rdata` is all zeros.
- R4: In master mode, contention means both `cs_n` are low and both addresses are equal. During contention exactly one `busy_n_o` is low, in the same cycle. Outside contention both are high.
- R5: If contention starts and at most one port was selected in the previous cycle, that previously selected port wins.
- R6: If contention starts and both ports were selected in the previous cycle, the right port wins only if its address equals its previous address and the left address does not. Otherwise the left port wins.
- R7: If contention starts with no order between the ports, the left port wins. This covers both ports selected together, and both addresses moving together.
- R8: An inhibited port's write does not change memory, and its read gives `rvalid`=0.
- R9: While contention lasts over consecutive cycles, the winner does not change. In the first cycle without contention, the former loser's access takes effect.
- R10: In slave mode both `busy_n_o` stay high, and a port whose `busy_n_i` is low is inhibited. In master mode `busy_n_i` has no effect.
- R11: Accesses by the two ports to different addresses in the same cycle both complete. A word written by one port is read by the other port one cycle later.
- R12: If both ports write the same address in one cycle without being inhibited, the left data is kept.
- R13: During reset and in the first cycle after it, both `rvalid` are 0, both `rdata` are zero, and both `busy_n_o` are high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| is_master | input | 1 | 1 selects master mode (internal arbitration); 0 selects slave mode (external busy) |
| l_cs_n | input | 1 | Left select, active low |
| l_we_n | input | 1 | Left write, active low (1 = read) |
| l_oe_n | input | 1 | Left read output enable, active low |
| l_addr | input | ADDR_W | Left address |
| l_wdata | input | DATA_W | Left write data |
| l_rdata | output | DATA_W | Left read data, zero when not valid |
| l_rvalid | output | 1 | Left read data valid |
| l_busy_n_i | input | 1 | Left busy from an external master, active low (slave mode) |
| l_busy_n_o | output | 1 | Left busy generated by the arbiter, active low (master mode) |
| r_cs_n | input | 1 | Right select, active low |
| r_we_n | input | 1 | Right write, active low (1 = read) |
| r_oe_n | input | 1 | Right read output enable, active low |
| r_addr | input | ADDR_W | Right address |
| r_wdata | input | DATA_W | Right write data |
| r_rdata | output | DATA_W | Right read data, zero when not valid |
| r_rvalid | output | 1 | Right read data valid |
| r_busy_n_i | input | 1 | Right busy from an external master, active low (slave mode) |
| r_busy_n_o | output | 1 | Right busy generated by the arbiter, active low (master mode) |

## Verification
The assertions take for granted that every input, including the slave-mode busy inputs, is stable around the clock edge and free of X once reset is released. They also assume that the busy outputs are sampled only after the current cycle's inputs have settled. The stimulus changes all inputs on the falling edge and reads the busy outputs before the next rising edge. It writes every word of the array before any read is compared, so read data is never undefined. Random traffic draws addresses from a small pool, and it holds or moves each port's select and address in ways that reach both arbitration modes and the tie case.

// File: rtl/dpr_pkg.sv
package dpr_pkg;

  typedef enum logic {
    SIDE_L = 1'b0,
    SIDE_R = 1'b1
  } side_e;

  typedef enum logic {
    ARB_BY_CS   = 1'b0,
    ARB_BY_ADDR = 1'b1
  } arb_mode_e;

  typedef struct packed {
    logic sel;
    logic wr;
    logic oe;
  } port_ctl_t;

  localparam int NUM_SIDES = 2;

endpackage

// File: rtl/dpr_arbiter.sv
module dpr_arbiter
  import dpr_pkg::*;
#(
  parameter int ADDR_W = 11
) (
  input  logic              clk,
  input  logic              rst_n,
  input  port_ctl_t         ctl_l,
  input  port_ctl_t         ctl_r,
  input  logic [ADDR_W-1:0] addr_l,
  input  logic [ADDR_W-1:0] addr_r,
  output logic              conflict,
  output logic              inh_l,
  output logic              inh_r
);

  logic              prev_sel_l, prev_sel_r, prev_conflict;
  logic [ADDR_W-1:0] prev_addr_l, prev_addr_r;
  side_e             owner_q, owner, fresh;
  arb_mode_e         mode;

  always_comb conflict = ctl_l.sel && ctl_r.sel && (addr_l == addr_r);

  // Winner of a newly started contention, from one cycle of history
  always_comb begin
    mode  = (prev_sel_l && prev_sel_r) ? ARB_BY_ADDR : ARB_BY_CS;
    fresh = SIDE_L;
    unique case (mode)
      ARB_BY_CS:   if (prev_sel_r && !prev_sel_l) fresh = SIDE_R;
      ARB_BY_ADDR: if ((addr_r == prev_addr_r) && (addr_l != prev_addr_l)) fresh = SIDE_R;
      default:     fresh = SIDE_L;
    endcase
    owner = prev_conflict ? owner_q : fresh;
  end

  always_comb begin
    inh_l = conflict && (owner == SIDE_R);
    inh_r = conflict && (owner == SIDE_L);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_sel_l    <= 1'b0;
      prev_sel_r    <= 1'b0;
      prev_addr_l   <= '0;
      prev_addr_r   <= '0;
      prev_conflict <= 1'b0;
      owner_q       <= SIDE_L;
    end else begin
      prev_sel_l    <= ctl_l.sel;
      prev_sel_r    <= ctl_r.sel;
      prev_addr_l   <= addr_l;
      prev_addr_r   <= addr_r;
      prev_conflict <= conflict;
      if (conflict) owner_q <= owner;
    end
  end

  // R9
  grant_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (conflict && prev_conflict) |-> (inh_l == $past(inh_l)) && (inh_r == $past(inh_r)));

  // R7
  tie_left_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (conflict && !prev_sel_l && !prev_sel_r) |-> !inh_l);

endmodule

// File: rtl/dpr_port_gate.sv
module dpr_port_gate
  import dpr_pkg::*;
(
  input  port_ctl_t ctl,
  input  logic      inhibit,
  output logic      wr_en,
  output logic      rd_en
);

  always_comb begin
    wr_en = ctl.sel && ctl.wr && !inhibit;
    rd_en = ctl.sel && !ctl.wr && ctl.oe && !inhibit;
  end

endmodule

// File: rtl/dpr_array.sv
module dpr_array
  import dpr_pkg::*;
#(
  parameter int ADDR_W = 11,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [1:0]        wr_en,
  input  logic [1:0]        rd_en,
  input  logic [ADDR_W-1:0] addr  [NUM_SIDES],
  input  logic [DATA_W-1:0] wdata [NUM_SIDES],
  output logic [DATA_W-1:0] rdata [NUM_SIDES],
  output logic [1:0]        rvalid
);

  localparam int DEPTH = 1 << ADDR_W;

  logic [DATA_W-1:0] mem [DEPTH];

  // Right is applied first so a same-address left write overrides it
  always_ff @(posedge clk) begin
    if (wr_en[1]) mem[addr[1]] <= wdata[1];
    if (wr_en[0]) mem[addr[0]] <= wdata[0];
  end

  for (genvar g = 0; g < NUM_SIDES; g++) begin : g_rd
    logic              rv_q;
    logic [DATA_W-1:0] rd_q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        rv_q <= 1'b0;
        rd_q <= '0;
      end else begin
        rv_q <= rd_en[g];
        if (rd_en[g]) rd_q <= mem[addr[g]];
      end
    end
    assign rvalid[g] = rv_q;
    assign rdata[g]  = rv_q ? rd_q : '0;
  end

endmodule

// File: rtl/dp_ram_arb.sv
module dp_ram_arb
  import dpr_pkg::*;
#(
  parameter int ADDR_W = 11,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              is_master,
  input  logic              l_cs_n,
  input  logic              l_we_n,
  input  logic              l_oe_n,
  input  logic [ADDR_W-1:0] l_addr,
  input  logic [DATA_W-1:0] l_wdata,
  output logic [DATA_W-1:0] l_rdata,
  output logic              l_rvalid,
  input  logic              l_busy_n_i,
  output logic              l_busy_n_o,
  input  logic              r_cs_n,
  input  logic              r_we_n,
  input  logic              r_oe_n,
  input  logic [ADDR_W-1:0] r_addr,
  input  logic [DATA_W-1:0] r_wdata,
  output logic [DATA_W-1:0] r_rdata,
  output logic              r_rvalid,
  input  logic              r_busy_n_i,
  output logic              r_busy_n_o
);

  port_ctl_t         ctl   [NUM_SIDES];
  logic [ADDR_W-1:0] addr  [NUM_SIDES];
  logic [DATA_W-1:0] wdata [NUM_SIDES];
  logic [DATA_W-1:0] rdata [NUM_SIDES];
  logic [1:0]        inh_eff, wr_en, rd_en, rvalid, ext_busy;
  logic              conflict, arb_inh_l, arb_inh_r;

  always_comb begin
    ctl[0]   = '{sel: !l_cs_n, wr: !l_we_n, oe: !l_oe_n};
    ctl[1]   = '{sel: !r_cs_n, wr: !r_we_n, oe: !r_oe_n};
    addr[0]  = l_addr;
    addr[1]  = r_addr;
    wdata[0] = l_wdata;
    wdata[1] = r_wdata;
    ext_busy = {!r_busy_n_i, !l_busy_n_i};
  end

  dpr_arbiter #(.ADDR_W(ADDR_W)) arb_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .ctl_l    (ctl[0]),
    .ctl_r    (ctl[1]),
    .addr_l   (l_addr),
    .addr_r   (r_addr),
    .conflict (conflict),
    .inh_l    (arb_inh_l),
    .inh_r    (arb_inh_r)
  );

  // Master uses its own arbiter, slave obeys the external busy lines
  always_comb inh_eff = is_master ? {arb_inh_r, arb_inh_l} : ext_busy;

  for (genvar g = 0; g < NUM_SIDES; g++) begin : g_port
    dpr_port_gate gate_i (
      .ctl     (ctl[g]),
      .inhibit (inh_eff[g]),
      .wr_en   (wr_en[g]),
      .rd_en   (rd_en[g])
    );
  end

  dpr_array #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) array_i (
    .clk    (clk),
    .rst_n  (rst_n),
    .wr_en  (wr_en),
    .rd_en  (rd_en),
    .addr   (addr),
    .wdata  (wdata),
    .rdata  (rdata),
    .rvalid (rvalid)
  );

  always_comb begin
    l_rdata    = rdata[0];
    r_rdata    = rdata[1];
    l_rvalid   = rvalid[0];
    r_rvalid   = rvalid[1];
    l_busy_n_o = !(is_master && arb_inh_l);
    r_busy_n_o = !(is_master && arb_inh_r);
  end

  // R4
  busy_pair_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(!l_busy_n_o && !r_busy_n_o));

  // R4
  busy_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!l_busy_n_o || !r_busy_n_o) |-> (!l_cs_n && !r_cs_n && (l_addr == r_addr)));

  // R4
  busy_present_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (is_master && conflict) |-> (l_busy_n_o != r_busy_n_o));

  // R10
  slave_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !is_master |-> (l_busy_n_o && r_busy_n_o));

  // R3
  l_rvalid_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    l_rvalid |-> $past(!l_cs_n && l_we_n && !l_oe_n));

  // R8
  r_inhibit_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $past(is_master && !r_busy_n_o) |-> !r_rvalid);

endmodule

// File: tb/dp_ram_arb_tb_top.sv
module dp_ram_arb_tb_top;

  localparam int AW = 11;
  localparam int DW = 8;
  localparam int DEPTH = 1 << AW;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic is_master = 1'b1;
  logic l_cs_n = 1'b1, l_we_n = 1'b1, l_oe_n = 1'b1, l_busy_n_i = 1'b1;
  logic r_cs_n = 1'b1, r_we_n = 1'b1, r_oe_n = 1'b1, r_busy_n_i = 1'b1;
  logic [AW-1:0] l_addr = '0, r_addr = '0;
  logic [DW-1:0] l_wdata = '0, r_wdata = '0;
  logic [DW-1:0] l_rdata, r_rdata;
  logic l_rvalid, r_rvalid, l_busy_n_o, r_busy_n_o;

  always #4 clk = ~clk;

  dp_ram_arb #(.ADDR_W(AW), .DATA_W(DW)) dut_i (.*);

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  // Reference model state
  logic [DW-1:0] mem_m [DEPTH];
  bit p_sel_l = 0, p_sel_r = 0, p_conf = 0, p_own_r = 0;
  logic [AW-1:0] p_addr_l = '0, p_addr_r = '0;
  bit e_rv_l = 0, e_rv_r = 0;
  logic [DW-1:0] e_rd_l = '0, e_rd_r = '0;

  function automatic logic [DW-1:0] pat(input int i);
    return DW'((i * 37 + 5) & 8'hFF);
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic report();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  endtask

  // One clock: check busy, advance model, check registered read outputs
  task automatic cycle();
    bit sl, sr, conf, own_r, inh_l, inh_r;
    #2;
    sl = !l_cs_n;
    sr = !r_cs_n;
    conf = sl && sr && (l_addr == r_addr);
    if (p_conf) own_r = p_own_r;
    else if (p_sel_l && p_sel_r) own_r = (r_addr == p_addr_r) && (l_addr != p_addr_l);
    else own_r = p_sel_r && !p_sel_l;
    if (is_master) begin
      inh_l = conf && own_r;
      inh_r = conf && !own_r;
    end else begin
      inh_l = !l_busy_n_i;
      inh_r = !r_busy_n_i;
    end
    chk(is_master ? "R4" : "R10", l_busy_n_o, !(is_master && conf && own_r));
    chk(is_master ? "R4" : "R10", r_busy_n_o, !(is_master && conf && !own_r));
    e_rv_l = sl && l_we_n && !l_oe_n && !inh_l;
    e_rv_r = sr && r_we_n && !r_oe_n && !inh_r;
    e_rd_l = e_rv_l ? mem_m[l_addr] : '0;
    e_rd_r = e_rv_r ? mem_m[r_addr] : '0;
    if (sr && !r_we_n && !inh_r) mem_m[r_addr] = r_wdata;
    if (sl && !l_we_n && !inh_l) mem_m[l_addr] = l_wdata;
    p_sel_l = sl; p_sel_r = sr; p_addr_l = l_addr; p_addr_r = r_addr;
    p_conf = conf;
    if (conf) p_own_r = own_r;
    @(posedge clk);
    @(negedge clk);
    chk("R3", l_rvalid, e_rv_l);
    chk("R3", r_rvalid, e_rv_r);
    chk("R1", l_rdata, e_rd_l);
    chk("R1", r_rdata, e_rd_r);
  endtask

  task automatic set_l(input bit cs, input bit we, input bit oe, input int a, input logic [DW-1:0] d);
    l_cs_n = cs; l_we_n = we; l_oe_n = oe; l_addr = AW'(a); l_wdata = d;
  endtask

  task automatic set_r(input bit cs, input bit we, input bit oe, input int a, input logic [DW-1:0] d);
    r_cs_n = cs; r_we_n = we; r_oe_n = oe; r_addr = AW'(a); r_wdata = d;
  endtask

  task automatic idle();
    set_l(1, 1, 1, 0, 0);
    set_r(1, 1, 1, 0, 0);
  endtask

  task automatic peek_busy(input string tag, input bit el, input bit er);
    #1;
    chk(tag, l_busy_n_o, el);
    chk(tag, r_busy_n_o, er);
  endtask

  // Read one word through the left port and compare
  task automatic read_l(input string tag, input int a, input logic [DW-1:0] exp);
    set_l(0, 1, 0, a, 0);
    set_r(1, 1, 1, 0, 0);
    cycle();
    chk(tag, l_rdata, exp);
  endtask

  initial begin
    #(8 * 200000);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL R1 watchdog: actual timeout expected completion");
      report();
    end
  end

  initial begin
    @(negedge clk);
    @(negedge clk);
    // R13 outputs during reset
    chk("R13", {l_rvalid, r_rvalid, l_busy_n_o, r_busy_n_o}, 4'b0011);
    chk("R13", {l_rdata, r_rdata}, 16'h0);
    rst_n = 1'b1;
    @(negedge clk);
    // R13 first cycle after reset
    chk("R13", {l_rvalid, r_rvalid, l_busy_n_o, r_busy_n_o}, 4'b0011);

    // R11: fill the array, both ports write distinct halves each cycle
    for (int i = 0; i < DEPTH / 2; i++) begin
      set_l(0, 0, 1, i, pat(i));
      set_r(0, 0, 1, i + DEPTH / 2, pat(i + DEPTH / 2));
      cycle();
    end
    set_l(0, 0, 1, 5, 8'h11);
    set_r(0, 0, 1, 9, 8'h22);
    cycle();
    set_l(0, 1, 0, 9, 0);
    set_r(0, 1, 0, 5, 0);
    cycle();
    chk("R11", l_rdata, 8'h22);
    chk("R11", r_rdata, 8'h11);

    // R2: deselected write is dropped and gives no read
    set_l(1, 0, 0, 3, 8'hAA);
    set_r(1, 1, 0, 3, 0);
    cycle();
    chk("R2", {l_rvalid, r_rvalid}, 2'b00);
    read_l("R2", 3, pat(3));

    // R3: read with output enable high
    set_l(0, 1, 1, 4, 0);
    idle_r();
    cycle();
    chk("R3", {l_rvalid, l_rdata}, 9'h0);

    // R5: left selected first, right joins at the same address
    idle();
    cycle();
    set_l(0, 1, 0, 100, 0);
    set_r(1, 1, 1, 100, 0);
    cycle();
    set_r(0, 0, 1, 100, 8'h5A);
    peek_busy("R5", 1, 0);
    cycle();
    read_l("R8", 100, pat(100));
    // R5: right selected first, left joins
    idle();
    cycle();
    set_r(0, 1, 0, 110, 0);
    cycle();
    set_l(0, 0, 1, 110, 8'h77);
    peek_busy("R5", 0, 1);
    cycle();
    chk("R5", r_rvalid, 1'b1);
    read_l("R8", 110, pat(110));

    // R6: both selected; right moves onto left's address -> left wins
    set_l(0, 1, 0, 200, 0);
    set_r(0, 1, 0, 201, 0);
    cycle();
    set_r(0, 0, 1, 200, 8'h33);
    peek_busy("R6", 1, 0);
    cycle();
    // R6: left moves onto right's address -> right wins, left write dropped
    idle();
    cycle();
    set_l(0, 1, 0, 210, 0);
    set_r(0, 1, 0, 211, 0);
    cycle();
    set_l(0, 0, 1, 211, 8'h44);
    peek_busy("R6", 0, 1);
    cycle();
    read_l("R8", 211, pat(211));

    // R7: both select the same address together
    idle();
    cycle();
    set_l(0, 1, 0, 220, 0);
    set_r(0, 0, 1, 220, 8'h99);
    peek_busy("R7", 1, 0);
    cycle();
    // R7: both selected, both addresses move to a common one
    set_l(0, 1, 0, 230, 0);
    set_r(0, 1, 0, 231, 0);
    cycle();
    set_l(0, 1, 0, 232, 0);
    set_r(0, 0, 1, 232, 8'h98);
    peek_busy("R7", 1, 0);
    cycle();

    // R9: right holds the grant, then leaves; left's write then lands
    idle();
    cycle();
    set_r(0, 1, 0, 240, 0);
    cycle();
    set_l(0, 0, 1, 240, 8'hC3);
    cycle();
    peek_busy("R9", 0, 1);
    cycle();
    set_r(1, 1, 1, 0, 0);
    peek_busy("R9", 1, 1);
    cycle();
    read_l("R9", 240, 8'hC3);

    // R12: slave, both write the same word without busy
    is_master = 1'b0;
    set_l(0, 0, 1, 300, 8'h1E);
    set_r(0, 0, 1, 300, 8'hE1);
    peek_busy("R10", 1, 1);
    cycle();
    read_l("R12", 300, 8'h1E);
    // R10: slave write with busy input low is dropped
    l_busy_n_i = 1'b0;
    set_l(0, 0, 1, 301, 8'h55);
    idle_r();
    cycle();
    l_busy_n_i = 1'b1;
    read_l("R10", 301, pat(301));
    // R10: master ignores busy inputs
    is_master = 1'b1;
    l_busy_n_i = 1'b0;
    r_busy_n_i = 1'b0;
    set_l(0, 0, 1, 302, 8'h66);
    cycle();
    read_l("R10", 302, 8'h66);
    l_busy_n_i = 1'b1;
    r_busy_n_i = 1'b1;

    // Random traffic over a small address pool, both modes
    for (int c = 0; c < 3000; c++) begin
      if (c % 250 == 0) is_master = ($urandom % 2) == 0;
      if (($urandom % 4) != 0)
        set_l(($urandom % 5) == 0, $urandom % 2, ($urandom % 6) == 0, 400 + $urandom % 3, DW'($urandom));
      if (($urandom % 4) != 0)
        set_r(($urandom % 5) == 0, $urandom % 2, ($urandom % 6) == 0, 400 + $urandom % 3, DW'($urandom));
      l_busy_n_i = ($urandom % 3) != 0;
      r_busy_n_i = ($urandom % 3) != 0;
      cycle();
    end

    done = 1'b1;
    report();
  end

  task automatic idle_r();
    set_r(1, 1, 1, 0, 0);
  endtask

endmodule